// File: doc/BRIEF.md
# Base Address Window Decoder

This block holds the six base-address registers and the 16-bit command register of one device's configuration header. Each region has a fixed power-of-two size and a fixed space type (I/O or memory), both chosen by parameters; a size code of zero marks a region as not implemented. Configuration software writes and reads these registers through a simple byte-addressed port. The block keeps an active mapping for each region and flags, one bit per region, which region an incoming I/O or memory access falls into.

A mapping goes live only when the space-enable bit for its type is set in the command register and its aligned base passes the validity rules. Any write that changes a base register or the command register schedules a re-evaluation of every mapping on the next clock. The decoder's hit outputs are registered.

Configuration accesses use `cfg_len` to give their width: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. Write data and read data are right-justified: byte lane i carries configuration offset `cfg_addr + i`.

Top module: `cfg_bar_decoder`

## Requirements
- R1: After reset the command register and all base registers read as zero, `rd_valid_o` is low and every hit bit is low.
- R2: A four-byte write whose offset lies in 0x10 to 0x27 updates base register (offset - 0x10) / 4 (offset bits [1:0] disregarded), storing the written value with its low log2(size) bits cleared.
- R3: One-byte and two-byte writes to offsets 0x10 to 0x27 leave every base register unchanged.
- R4: A region whose size code is zero reads as zero at all four of its offsets, ignores writes and never raises its hit bit.
- R5: Bytes 0x04 and 0x05 form the command register and accept writes of any width that covers them; command bit 0 enables I/O regions and bit 1 enables memory regions, and a region in a disabled space never hits.
- R6: An I/O mapping is valid only if its aligned base is nonzero, its last address does not wrap past 0xFFFFFFFF and its last address is below 0x10000.
- R7: A memory mapping is valid only if its aligned base is nonzero and its last address does not wrap past 0xFFFFFFFF.
- R8: `hit_o[k]` rises one cycle after an access address is presented exactly when region k is mapped, its type matches `acc_is_io` (1 = I/O), and the address lies between the base and base + size - 1.
- R9: A write touching a base register or the command register re-evaluates all mappings: an access presented in the cycle right after the write still sees the old mapping, and one presented two cycles after sees the new one.
- R10: A read returns, one cycle later with `rd_valid_o` high, the stored little-endian bytes starting at `cfg_addr` for 1, 2 or 4 lanes, with unused lanes and offsets outside the command and base registers reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_len | input | 2 | Access width code: 0 byte, 1 word, 2 or 3 dword |
| cfg_wdata | input | 32 | Right-justified write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after `cfg_rd` |
| rd_data_o | output | 32 | Right-justified read data |
| acc_addr | input | 32 | Address of an incoming access to decode |
| acc_is_io | input | 1 | Access space: 1 I/O, 0 memory |
| hit_o | output | NUM_BARS | Per-region hit flags, registered |

## Verification
The bench aims at the alignment mask, the narrow-write exclusion, and an absent region. A design that masked the wrong number of bits would read back a misaligned base, and one that let byte writes through would corrupt a base. The validity edges are tested with an I/O window ending at exactly 0xFFFF against one crossing 0x10000, a zero base, and a memory window ending at 0xFFFFFFFF; a decoder that got these wrong would claim illegal ranges or drop the topmost legal one. A command write followed at once by a lookup checks the one-cycle re-evaluation latency, which a design that updated mappings too early or too late would break.

// File: rtl/cfg_bar_pkg.sv
package cfg_bar_pkg;

  typedef enum logic [1:0] {
    LEN_BYTE    = 2'd0,
    LEN_WORD    = 2'd1,
    LEN_DWORD   = 2'd2,
    LEN_DWORD_X = 2'd3
  } cfg_len_e;

  localparam logic [7:0] CMD_LO_OFS  = 8'h04;
  localparam logic [7:0] CMD_HI_OFS  = 8'h05;
  localparam logic [7:0] BAR_WIN_OFS = 8'h10;

  localparam int CMD_IO_BIT  = 0;
  localparam int CMD_MEM_BIT = 1;

  // width of one per-region size code in the packed parameter vector
  localparam int SZ_CODE_W = 5;

  function automatic logic [2:0] lane_count(input logic [1:0] len);
    case (cfg_len_e'(len))
      LEN_BYTE: lane_count = 3'd1;
      LEN_WORD: lane_count = 3'd2;
      default:  lane_count = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
  parameter int LOG2          = 4,
  parameter bit IS_IO         = 1'b1,
  parameter int IO_LIMIT_LOG2 = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        refresh,
  input  logic        space_en,
  output logic [31:0] bar_value,
  output logic        map_en,
  output logic [31:0] map_base
);

  generate
    if (LOG2 == 0) begin : g_absent
      logic unused_slot;
      assign unused_slot = ^{clk, rst, wr_en, wdata, refresh, space_en};
      assign bar_value   = '0;
      assign map_en      = 1'b0;
      assign map_base    = '0;
    end else begin : g_impl
      localparam logic [31:0] LOW_MASK = 32'hFFFF_FFFF >> (32 - LOG2);
      localparam logic [32:0] SPAN     = {1'b0, LOW_MASK};
      localparam logic [32:0] IO_TOP   = 33'd1 << IO_LIMIT_LOG2;

      logic [31:0] bar_q;
      logic [31:0] base_q;
      logic        en_q;
      logic [32:0] last_w;
      logic        ok_w;

      always_ff @(posedge clk) begin
        if (rst)        bar_q <= '0;
        else if (wr_en) bar_q <= wdata & ~LOW_MASK;
      end

      assign last_w = {1'b0, bar_q} + SPAN;

      always_comb begin
        ok_w = (bar_q != 32'd0) && !last_w[32] && (last_w[31:0] > bar_q);
        if (IS_IO) ok_w = ok_w && (last_w < IO_TOP);
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          en_q   <= 1'b0;
          base_q <= '0;
        end else if (refresh) begin
          en_q   <= space_en && ok_w;
          base_q <= bar_q;
        end
      end

      assign bar_value = bar_q;
      assign map_en    = en_q;
      assign map_base  = base_q;
    end
  endgenerate

endmodule

// File: rtl/cfg_bar_match.sv
module cfg_bar_match #(
  parameter int                          NUM      = 6,
  parameter logic [NUM*5-1:0]            LOG2_VEC = '0,
  parameter logic [NUM-1:0]              IO_VEC   = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [31:0]           acc_addr,
  input  logic                  acc_is_io,
  input  logic [NUM-1:0]        map_en,
  input  logic [NUM-1:0][31:0]  map_base,
  output logic [NUM-1:0]        hit
);

  logic [NUM-1:0] match_w;
  logic [NUM-1:0] hit_q;

  generate
    for (genvar k = 0; k < NUM; k++) begin : g_cmp
      localparam int          L    = int'(LOG2_VEC[k*5 +: 5]);
      localparam logic [31:0] MASK = (L == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - L));
      assign match_w[k] = map_en[k] && (IO_VEC[k] == acc_is_io) &&
                          ((acc_addr & ~MASK) == map_base[k]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hit_q <= '0;
    else     hit_q <= match_w;
  end

  assign hit = hit_q;

endmodule

// File: rtl/cfg_bar_decoder.sv
module cfg_bar_decoder
  import cfg_bar_pkg::*;
#(
  parameter int                        NUM_BARS      = 6,
  parameter logic [NUM_BARS*5-1:0]     BAR_LOG2      = {5'd16, 5'd0, 5'd20, 5'd8, 5'd12, 5'd4},
  parameter logic [NUM_BARS-1:0]       BAR_IS_IO     = 6'b000101,
  parameter int                        IO_LIMIT_LOG2 = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [7:0]          cfg_addr,
  input  logic [1:0]          cfg_len,
  input  logic [31:0]         cfg_wdata,
  output logic                rd_valid_o,
  output logic [31:0]         rd_data_o,
  input  logic [31:0]         acc_addr,
  input  logic                acc_is_io,
  output logic [NUM_BARS-1:0] hit_o
);

  localparam logic [8:0] WIN_LO = {1'b0, BAR_WIN_OFS};
  localparam logic [8:0] WIN_HI = WIN_LO + 9'(4 * NUM_BARS);
  localparam logic [5:0] WIN_DW = 6'(BAR_WIN_OFS >> 2);

  logic [2:0]  nbytes;
  logic [7:0]  lane_ofs [4];
  logic [3:0]  lane_on;
  logic        cmd_touch;
  logic        in_win;
  logic [5:0]  bar_idx;
  logic [NUM_BARS-1:0] bar_wr;
  logic [15:0] cmd_q;
  logic        refresh_q;
  logic [NUM_BARS-1:0]       map_en;
  logic [NUM_BARS-1:0][31:0] map_base;
  logic [NUM_BARS-1:0][31:0] bar_val;
  logic [31:0] rd_w;
  logic        rd_valid_q;
  logic [31:0] rd_data_q;

  assign nbytes = lane_count(cfg_len);

  always_comb begin
    cmd_touch = 1'b0;
    for (int i = 0; i < 4; i++) begin
      lane_ofs[i] = cfg_addr + 8'(i);
      lane_on[i]  = 3'(i) < nbytes;
      if (lane_on[i] && (lane_ofs[i] == CMD_LO_OFS || lane_ofs[i] == CMD_HI_OFS))
        cmd_touch = 1'b1;
    end
  end

  assign in_win  = ({1'b0, cfg_addr} >= WIN_LO) && ({1'b0, cfg_addr} < WIN_HI);
  assign bar_idx = 6'((cfg_addr - BAR_WIN_OFS) >> 2);

  generate
    for (genvar k = 0; k < NUM_BARS; k++) begin : g_wsel
      assign bar_wr[k] = cfg_wr && cfg_len[1] && in_win && (bar_idx == 6'(k));
    end
  endgenerate

  // command register, byte-writable
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (cfg_wr) begin
      for (int i = 0; i < 4; i++) begin
        if (lane_on[i] && lane_ofs[i] == CMD_LO_OFS) cmd_q[7:0]  <= cfg_wdata[8*i +: 8];
        if (lane_on[i] && lane_ofs[i] == CMD_HI_OFS) cmd_q[15:8] <= cfg_wdata[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) refresh_q <= 1'b0;
    else     refresh_q <= (cfg_wr && cmd_touch) || (|bar_wr);
  end

  generate
    for (genvar k = 0; k < NUM_BARS; k++) begin : g_slot
      localparam int L = int'(BAR_LOG2[k*SZ_CODE_W +: SZ_CODE_W]);
      logic space_en;
      assign space_en = BAR_IS_IO[k] ? cmd_q[CMD_IO_BIT] : cmd_q[CMD_MEM_BIT];
      cfg_bar_slot #(
        .LOG2          (L),
        .IS_IO         (BAR_IS_IO[k]),
        .IO_LIMIT_LOG2 (IO_LIMIT_LOG2)
      ) slot_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bar_wr[k]),
        .wdata     (cfg_wdata),
        .refresh   (refresh_q),
        .space_en  (space_en),
        .bar_value (bar_val[k]),
        .map_en    (map_en[k]),
        .map_base  (map_base[k])
      );
    end
  endgenerate

  cfg_bar_match #(
    .NUM      (NUM_BARS),
    .LOG2_VEC (BAR_LOG2),
    .IO_VEC   (BAR_IS_IO)
  ) match_i (
    .clk       (clk),
    .rst       (rst),
    .acc_addr  (acc_addr),
    .acc_is_io (acc_is_io),
    .map_en    (map_en),
    .map_base  (map_base),
    .hit       (hit_o)
  );

  // read lane assembly
  always_comb begin
    rd_w = '0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] rb;
      rb = 8'h00;
      if (lane_ofs[i] == CMD_LO_OFS) rb = cmd_q[7:0];
      else if (lane_ofs[i] == CMD_HI_OFS) rb = cmd_q[15:8];
      else begin
        for (int k = 0; k < NUM_BARS; k++) begin
          if (lane_ofs[i][7:2] == WIN_DW + 6'(k))
            rb = bar_val[k][{lane_ofs[i][1:0], 3'b000} +: 8];
        end
      end
      if (lane_on[i]) rd_w[8*i +: 8] = rb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= cfg_rd;
      if (cfg_rd) rd_data_q <= rd_w;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

endmodule

// File: rtl/cfg_bar_decoder_chk.sv
module cfg_bar_decoder_chk #(
  parameter int                  NUM_BARS  = 6,
  parameter logic [NUM_BARS-1:0] BAR_IS_IO = '0
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_wr,
  input logic                cfg_rd,
  input logic [7:0]          cfg_addr,
  input logic [31:0]         acc_addr,
  input logic                acc_is_io,
  input logic                rd_valid_o,
  input logic [NUM_BARS-1:0] hit_o,
  input logic [15:0]         cmd_q,
  input logic                refresh_q
);

  // R10: read data arrives one cycle after the strobe
  p_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |=> rd_valid_o);
  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> !rd_valid_o);

  // R9: a command write schedules re-evaluation
  p_cmd_refresh_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == 8'h04) |=> refresh_q);

  generate
    for (genvar k = 0; k < NUM_BARS; k++) begin : g_chk
      localparam int EB = BAR_IS_IO[k] ? 0 : 1;
      // R8: a hit only for an access of the region's own space
      p_hit_space_r8: assert property (@(posedge clk) disable iff (rst)
        hit_o[k] |-> ($past(acc_is_io) == BAR_IS_IO[k]));
      // R5: a hit needs the space enable in force at re-evaluation
      p_hit_enable_r5: assert property (@(posedge clk) disable iff (rst)
        hit_o[k] |-> $past(cmd_q[EB], 2));
      if (BAR_IS_IO[k]) begin : g_io
        // R6: I/O hits stay below 64K
        p_io_window_r6: assert property (@(posedge clk) disable iff (rst)
          hit_o[k] |-> ($past(acc_addr) < 32'h0001_0000));
      end
    end
  endgenerate

endmodule

bind cfg_bar_decoder cfg_bar_decoder_chk #(
  .NUM_BARS  (NUM_BARS),
  .BAR_IS_IO (BAR_IS_IO)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .cfg_rd     (cfg_rd),
  .cfg_addr   (cfg_addr),
  .acc_addr   (acc_addr),
  .acc_is_io  (acc_is_io),
  .rd_valid_o (rd_valid_o),
  .hit_o      (hit_o),
  .cmd_q      (cmd_q),
  .refresh_q  (refresh_q)
);

// File: tb/cfg_bar_decoder_tb_top.sv
`timescale 1ns/1ps
module cfg_bar_decoder_tb_top;

  localparam int NB = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic          cfg_rd = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [1:0]    cfg_len = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          rd_valid_o;
  logic [31:0]   rd_data_o;
  logic [31:0]   acc_addr = '0;
  logic          acc_is_io = 1'b0;
  logic [NB-1:0] hit_o;

  always #2 clk = ~clk;

  cfg_bar_decoder dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_len(cfg_len), .cfg_wdata(cfg_wdata),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .acc_addr(acc_addr), .acc_is_io(acc_is_io), .hit_o(hit_o)
  );

  // bench view of the configuration: sizes and types
  int unsigned sz_l2 [NB] = '{4, 12, 8, 20, 0, 16};
  bit          is_io [NB] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  logic [31:0] m_bar [NB];
  logic [15:0] m_cmd;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // scoreboard
  int          q_due  [$];
  int          q_kind [$];
  logic [31:0] q_exp  [$];
  string       q_req  [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] m_byte(input logic [7:0] ofs);
    m_byte = 8'h00;
    if (ofs == 8'h04) m_byte = m_cmd[7:0];
    else if (ofs == 8'h05) m_byte = m_cmd[15:8];
    else if (ofs >= 8'h10 && ofs < 8'h28) m_byte = m_bar[(ofs - 8'h10) >> 2][8*ofs[1:0] +: 8];
  endfunction

  function automatic int nlanes(input logic [1:0] len);
    nlanes = (len == 2'd0) ? 1 : (len == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [NB-1:0] model_hits(input logic [31:0] a, input bit io);
    model_hits = '0;
    for (int k = 0; k < NB; k++) begin
      longint unsigned base, last;
      bit ok, en;
      if (sz_l2[k] == 0) continue;
      base = 64'(m_bar[k]);
      last = base + (64'd1 << sz_l2[k]) - 1;
      ok = (base != 0) && (last <= 64'hFFFF_FFFF) && (last > base);
      if (is_io[k]) ok = ok && (last < 64'h1_0000);
      en = is_io[k] ? m_cmd[0] : m_cmd[1];
      if (ok && en && (is_io[k] == io) && ((a >> sz_l2[k]) == (m_bar[k] >> sz_l2[k])))
        model_hits[k] = 1'b1;
    end
  endfunction

  task automatic push(input int kind, input logic [31:0] e, input string req);
    q_due.push_back(cyc + 1);
    q_kind.push_back(kind);
    q_exp.push_back(e);
    q_req.push_back(req);
  endtask

  task automatic model_write(input logic [7:0] a, input logic [1:0] len, input logic [31:0] d);
    for (int i = 0; i < nlanes(len); i++) begin
      logic [7:0] o;
      o = a + 8'(i);
      if (o == 8'h04) m_cmd[7:0]  = d[8*i +: 8];
      if (o == 8'h05) m_cmd[15:8] = d[8*i +: 8];
    end
    if (len[1] && a >= 8'h10 && a < 8'h28) begin
      int k;
      k = int'((a - 8'h10) >> 2);
      if (sz_l2[k] != 0) m_bar[k] = d & ~((32'd1 << sz_l2[k]) - 32'd1);
    end
  endtask

  task automatic cfg_write_fast(input logic [7:0] a, input logic [1:0] len, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_len = len; cfg_wdata = d;
    model_write(a, len, d);
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [1:0] len, input logic [31:0] d);
    cfg_write_fast(a, len, d);
    @(posedge clk); #1;
  endtask

  task automatic cfg_read(input logic [7:0] a, input logic [1:0] len, input string req);
    logic [31:0] e;
    e = '0;
    for (int i = 0; i < nlanes(len); i++) e[8*i +: 8] = m_byte(a + 8'(i));
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a; cfg_len = len;
    push(0, e, req);
    @(posedge clk); #1;
    cfg_rd = 1'b0;
  endtask

  task automatic lookup_exp(input logic [31:0] a, input bit io, input logic [NB-1:0] e, input string req);
    @(negedge clk);
    acc_addr = a; acc_is_io = io;
    push(1, 32'(e), req);
    @(posedge clk); #1;
  endtask

  task automatic lookup(input logic [31:0] a, input bit io, input string req);
    lookup_exp(a, io, model_hits(a, io), req);
  endtask

  // monitor
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      int k; logic [31:0] e; string r;
      k = q_kind.pop_front(); e = q_exp.pop_front(); r = q_req.pop_front();
      void'(q_due.pop_front());
      n_chk++;
      if (k == 0) begin
        if (!rd_valid_o || rd_data_o !== e) begin
          n_fail++;
          $display("FAIL %s: read valid=%b data=%h expected valid=1 data=%h", r, rd_valid_o, rd_data_o, e);
        end
      end else begin
        if (hit_o !== e[NB-1:0]) begin
          n_fail++;
          $display("FAIL %s: hit=%b expected %b (addr %h io %b)", r, hit_o, e[NB-1:0], acc_addr, acc_is_io);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] old_hits;
    for (int k = 0; k < NB; k++) m_bar[k] = '0;
    m_cmd = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    n_chk++;
    if (hit_o !== '0 || rd_valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: hit=%b rd_valid=%b expected 0 and 0", hit_o, rd_valid_o);
    end
    cfg_read(8'h10, 2'd2, "R1");
    cfg_read(8'h04, 2'd1, "R1");
    lookup(32'h0000_0000, 1'b1, "R1");

    // R2: dword writes with alignment masking
    cfg_write(8'h10, 2'd2, 32'h0000_C0F7);
    cfg_read(8'h10, 2'd2, "R2");
    cfg_write(8'h14, 2'd2, 32'hFEBC_1234);
    cfg_read(8'h14, 2'd2, "R2");
    cfg_write(8'h18, 2'd2, 32'h0000_C1FF);
    cfg_write(8'h1C, 2'd2, 32'hE001_2345);
    cfg_read(8'h1C, 2'd2, "R2");
    cfg_write(8'h24, 2'd2, 32'hF000_5555);
    // unaligned dword offset selects register (0x26-0x10)/4 = 5
    cfg_write(8'h26, 2'd2, 32'hF001_0000);
    cfg_read(8'h24, 2'd3, "R2");

    // R4: absent region
    cfg_write(8'h20, 2'd2, 32'hFFFF_FFFF);
    cfg_read(8'h20, 2'd2, "R4");
    cfg_read(8'h23, 2'd0, "R4");

    // R10: narrow reads at odd offsets, outside window
    cfg_read(8'h15, 2'd0, "R10");
    cfg_read(8'h16, 2'd1, "R10");
    cfg_read(8'h30, 2'd2, "R10");
    cfg_read(8'h0F, 2'd1, "R10");

    // R5: nothing enabled yet
    lookup(32'h0000_C0F4, 1'b1, "R5");
    lookup(32'hFEBC_1800, 1'b0, "R5");

    // R5: word write enables I/O only
    cfg_write(8'h04, 2'd1, 32'h0000_0001);
    lookup_exp(32'h0000_C0F4, 1'b1, 6'b000001, "R8");
    lookup(32'h0000_C105, 1'b1, "R8");
    lookup_exp(32'hFEBC_1800, 1'b0, 6'b000000, "R5");
    lookup_exp(32'h0000_C0F4, 1'b0, 6'b000000, "R8");

    // R5: byte write enables memory too
    cfg_write(8'h04, 2'd0, 32'h0000_0003);
    lookup_exp(32'hFEBC_1FFC, 1'b0, 6'b000010, "R8");
    lookup_exp(32'hE00F_FFFF, 1'b0, 6'b001000, "R8");
    lookup_exp(32'hFEBC_2000, 1'b0, 6'b000000, "R8");
    lookup(32'hF001_ABCD, 1'b0, "R8");
    lookup(32'hFFFF_FFFF, 1'b0, "R4");

    // R3: narrow writes to base registers are dropped
    cfg_write(8'h11, 2'd0, 32'h0000_0077);
    cfg_read(8'h10, 2'd2, "R3");
    cfg_write(8'h12, 2'd1, 32'h0000_FFFF);
    cfg_read(8'h10, 2'd2, "R3");
    lookup_exp(32'h0000_C0F0, 1'b1, 6'b000001, "R3");

    // R6: I/O window edges
    cfg_write(8'h18, 2'd2, 32'h0000_FF00);
    lookup_exp(32'h0000_FF80, 1'b1, 6'b000100, "R6");
    cfg_write(8'h18, 2'd2, 32'h0001_0000);
    lookup_exp(32'h0001_0000, 1'b1, 6'b000000, "R6");
    cfg_write(8'h10, 2'd2, 32'h0000_000F);
    lookup_exp(32'h0000_0000, 1'b1, 6'b000000, "R6");

    // R7: memory zero base and top-of-space window
    cfg_write(8'h14, 2'd2, 32'h0000_0FFF);
    lookup_exp(32'h0000_0000, 1'b0, 6'b000000, "R7");
    cfg_write(8'h1C, 2'd2, 32'hFFF0_0000);
    lookup_exp(32'hFFFF_FFF0, 1'b0, 6'b001000, "R7");

    // R9: immediate lookup sees old mapping, next one the new
    old_hits = model_hits(32'hFFFF_FFF0, 1'b0);
    cfg_write_fast(8'h04, 2'd2, 32'h0000_0001);
    lookup_exp(32'hFFFF_FFF0, 1'b0, old_hits, "R9");
    lookup_exp(32'hFFFF_FFF0, 1'b0, 6'b000000, "R9");
    cfg_read(8'h04, 2'd2, "R10");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule